// File: doc/BRIEF.md
# Three-Way Bus Grant Requester

This block lets a DMA engine win a shared system bus from a host processor with a three-signal handshake: request, grant and grant-acknowledge. When the engine needs the bus, the block pulls its active-low request line low and waits for the processor's grant. A grant is not enough to take the bus. The previous master must have dropped its own grant-acknowledge and its address strobe. The previous slave must have withdrawn every data-size acknowledge. In asynchronous bus mode, the slave must also have withdrawn its synchronous terminate.

Once all of those lines read inactive, the block drives grant-acknowledge low, withdraws the request and raises an internal ownership enable for the transfer engine. Grant changes do not end ownership. Ownership ends only when the engine reports the end of its block transfer, or reports that it is moving to a different memory area. In either case one holding cycle follows with grant-acknowledge still asserted, and then the bus is released. An area change also re-requests the bus at once, without waiting for a fresh need. All monitored bus-status lines are registered on the rising clock edge before they are evaluated. The block has no data path, so no valid/ready interface applies: every pin is a plain level-sensitive control or status line.

Top module: `bus_grant_requester`

## Requirements
- R1: While synchronous reset is high, and in the cycle after it, the request and grant-acknowledge outputs are high (inactive) and the ownership enable is low.
- R2: When the engine need input is high while the block is idle, the request output goes low after the next rising edge. It stays low until the block takes ownership.
- R3: Ownership is taken only when all of the following hold at the edge before the claiming edge: grant is low, the foreign grant-acknowledge is high, the address strobe is high, and every data-size acknowledge is high. Bus-status lines pass through one register stage, so a line change shows its effect one edge later.
- R4: The synchronous terminate input blocks ownership when it is low and the asynchronous-mode input is high. When the asynchronous-mode input is low, terminate has no effect.
- R5: In the cycle ownership begins, grant-acknowledge goes low, the ownership enable goes high and the request returns high, all together.
- R6: While the block owns the bus, grant changes and bus-status changes have no effect. Ownership holds until the done or area-change input is sampled high.
- R7: After done or area-change is sampled, there is exactly one holding cycle with grant-acknowledge low and the ownership enable low. Then grant-acknowledge goes high.
- R8: When area-change ends ownership, the request goes low again in the cycle right after the holding cycle, even with the need input low. Area-change takes priority over done when both are sampled high together.
- R9: The request and grant-acknowledge outputs are never low together. A high ownership enable always comes with a low grant-acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| need_i | input | 1 | Engine needs the bus |
| done_i | input | 1 | Last transfer cycle of the block is complete |
| area_chg_i | input | 1 | Engine is moving to another memory area |
| async_mode_i | input | 1 | 1 selects asynchronous bus mode, in which terminate is checked |
| bg_n_i | input | 1 | Bus grant from the processor, active low |
| bgack_n_i | input | 1 | Grant-acknowledge of other masters, active low |
| as_n_i | input | 1 | Address strobe of the bus, active low |
| dsack_n_i | input | DSACK_W | Data-size acknowledges, active low |
| sterm_n_i | input | 1 | Synchronous terminate, active low |
| br_n_o | output | 1 | Bus request, active low |
| bgack_n_o | output | 1 | Grant-acknowledge driven by this block, active low |
| own_o | output | 1 | Internal enable: transfers may run |

## Verification
The bound checker watches every cycle for the output rules that do not depend on history beyond a few edges. These are the reset values, the exclusion of request against grant-acknowledge, the coincidence of the ownership start with request withdrawal, the persistence of the request and of ownership, the single holding cycle, and the condition of each bus-status line two edges before a claim, including terminate only in asynchronous mode. Only the bench's scenarios can show that a busy line really delays the claim by the right number of cycles. The same holds for the terminate line having no effect when asynchronous mode is off, for an area change re-requesting with need low, and for area-change winning over done. The bench compares every output on every cycle against its own cycle model, under random bus traffic and directed cases.

// File: rtl/bgr_pkg.sv
package bgr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_HOLD = 2'd3
  } acq_state_e;

  // bit positions inside the packed bus-status vector
  localparam int IX_BG    = 0;
  localparam int IX_BGACK = 1;
  localparam int IX_AS    = 2;
  localparam int IX_STERM = 3;
  localparam int IX_DSACK = 4;

  function automatic int status_width(input int dsack_w);
    return dsack_w + IX_DSACK;
  endfunction
endpackage

// File: rtl/bgr_status_reg.sv
module bgr_status_reg #(
  parameter int W      = 6,
  parameter int STAGES = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES+1];

  assign chain[0] = d_i;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s+1] <= '1;  // all lines read inactive
      else     chain[s+1] <= chain[s];
    end
  end

  assign q_o = chain[STAGES];
endmodule

// File: rtl/bgr_idle_check.sv
module bgr_idle_check
  import bgr_pkg::*;
#(
  parameter int DSACK_W = 2,
  localparam int SW = DSACK_W + IX_DSACK
) (
  input  logic [SW-1:0] stat_i,
  input  logic          async_mode_i,
  output logic          granted_o,
  output logic          bus_free_o
);
  logic master_gone;
  logic slave_gone;
  logic term_gone;

  assign granted_o   = ~stat_i[IX_BG];
  assign master_gone = stat_i[IX_BGACK] & stat_i[IX_AS];
  assign slave_gone  = &stat_i[SW-1:IX_DSACK];
  assign term_gone   = stat_i[IX_STERM] | ~async_mode_i;
  assign bus_free_o  = master_gone & slave_gone & term_gone;
endmodule

// File: rtl/bgr_acq_fsm.sv
module bgr_acq_fsm
  import bgr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic need_i,
  input  logic done_i,
  input  logic area_chg_i,
  input  logic granted_i,
  input  logic bus_free_i,
  output logic br_n_o,
  output logic bgack_n_o,
  output logic own_o
);
  acq_state_e st_q, st_d;
  logic       rereq_q, rereq_d;

  always_comb begin
    st_d    = st_q;
    rereq_d = rereq_q;
    unique case (st_q)
      ST_IDLE: if (need_i) st_d = ST_REQ;
      ST_REQ:  if (granted_i && bus_free_i) st_d = ST_OWN;
      ST_OWN:  if (done_i || area_chg_i) begin
                 st_d    = ST_HOLD;
                 rereq_d = area_chg_i;
               end
      ST_HOLD: begin
                 st_d    = rereq_q ? ST_REQ : ST_IDLE;
                 rereq_d = 1'b0;
               end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      rereq_q   <= 1'b0;
      br_n_o    <= 1'b1;
      bgack_n_o <= 1'b1;
      own_o     <= 1'b0;
    end else begin
      st_q      <= st_d;
      rereq_q   <= rereq_d;
      br_n_o    <= (st_d != ST_REQ);
      bgack_n_o <= !(st_d == ST_OWN || st_d == ST_HOLD);
      own_o     <= (st_d == ST_OWN);
    end
  end
endmodule

// File: rtl/bus_grant_requester.sv
module bus_grant_requester
  import bgr_pkg::*;
#(
  parameter int DSACK_W     = 2,
  parameter int STAT_STAGES = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               need_i,
  input  logic               done_i,
  input  logic               area_chg_i,
  input  logic               async_mode_i,
  input  logic               bg_n_i,
  input  logic               bgack_n_i,
  input  logic               as_n_i,
  input  logic [DSACK_W-1:0] dsack_n_i,
  input  logic               sterm_n_i,
  output logic               br_n_o,
  output logic               bgack_n_o,
  output logic               own_o
);
  localparam int SW = DSACK_W + IX_DSACK;

  logic [SW-1:0] stat_raw;
  logic [SW-1:0] stat_q;
  logic          granted;
  logic          bus_free;

  assign stat_raw = {dsack_n_i, sterm_n_i, as_n_i, bgack_n_i, bg_n_i};

  bgr_status_reg #(.W(SW), .STAGES(STAT_STAGES)) u_stat (
    .clk (clk),
    .rst (rst),
    .d_i (stat_raw),
    .q_o (stat_q)
  );

  bgr_idle_check #(.DSACK_W(DSACK_W)) u_idle (
    .stat_i       (stat_q),
    .async_mode_i (async_mode_i),
    .granted_o    (granted),
    .bus_free_o   (bus_free)
  );

  bgr_acq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .need_i     (need_i),
    .done_i     (done_i),
    .area_chg_i (area_chg_i),
    .granted_i  (granted),
    .bus_free_i (bus_free),
    .br_n_o     (br_n_o),
    .bgack_n_o  (bgack_n_o),
    .own_o      (own_o)
  );
endmodule

// File: rtl/bgr_checker.sv
module bgr_checker #(
  parameter int DSACK_W     = 2,
  parameter int STAT_STAGES = 1
) (
  input logic               clk,
  input logic               rst,
  input logic               need_i,
  input logic               done_i,
  input logic               area_chg_i,
  input logic               async_mode_i,
  input logic               bg_n_i,
  input logic               bgack_n_i,
  input logic               as_n_i,
  input logic [DSACK_W-1:0] dsack_n_i,
  input logic               sterm_n_i,
  input logic               br_n_o,
  input logic               bgack_n_o,
  input logic               own_o
);
  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (br_n_o && bgack_n_o && !own_o)); // R1

  AST_REQ_PERSISTS: assert property (@(posedge clk) disable iff (rst)
    !br_n_o |=> (!br_n_o || !bgack_n_o)); // R2

  AST_CLAIM_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(bgack_n_o) |-> (br_n_o && own_o)); // R5

  AST_OWN_KEPT: assert property (@(posedge clk) disable iff (rst)
    (own_o && !done_i && !area_chg_i) |=> own_o); // R6

  AST_HOLD_CYCLE: assert property (@(posedge clk) disable iff (rst)
    $fell(own_o) |-> !bgack_n_o); // R7

  AST_HOLD_ENDS: assert property (@(posedge clk) disable iff (rst)
    $fell(own_o) |=> bgack_n_o); // R7

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(!br_n_o && !bgack_n_o)); // R9

  AST_OWN_ACKED: assert property (@(posedge clk) disable iff (rst)
    own_o |-> !bgack_n_o); // R9

  if (STAT_STAGES == 1) begin : g_claim
    AST_CLAIM_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
      $fell(bgack_n_o) |-> (!$past(bg_n_i, 2) && $past(bgack_n_i, 2) &&
                            $past(as_n_i, 2) && (&$past(dsack_n_i, 2)))); // R3

    AST_CLAIM_TERM: assert property (@(posedge clk) disable iff (rst)
      ($fell(bgack_n_o) && $past(async_mode_i)) |-> $past(sterm_n_i, 2)); // R4
  end
endmodule

bind bus_grant_requester bgr_checker #(
  .DSACK_W     (DSACK_W),
  .STAT_STAGES (STAT_STAGES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .need_i       (need_i),
  .done_i       (done_i),
  .area_chg_i   (area_chg_i),
  .async_mode_i (async_mode_i),
  .bg_n_i       (bg_n_i),
  .bgack_n_i    (bgack_n_i),
  .as_n_i       (as_n_i),
  .dsack_n_i    (dsack_n_i),
  .sterm_n_i    (sterm_n_i),
  .br_n_o       (br_n_o),
  .bgack_n_o    (bgack_n_o),
  .own_o        (own_o)
);

// File: tb/bus_grant_requester_test.sv
module bus_grant_requester_test;
  localparam int CLK_PERIOD = 10;
  localparam int DSACK_W    = 2;
  localparam int WATCHDOG   = 50000;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               need_i = 1'b0, done_i = 1'b0, area_chg_i = 1'b0;
  logic               async_mode_i = 1'b0;
  logic               bg_n_i = 1'b1, bgack_n_i = 1'b1, as_n_i = 1'b1, sterm_n_i = 1'b1;
  logic [DSACK_W-1:0] dsack_n_i = '1;
  logic               br_n_o, bgack_n_o, own_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_grant_requester #(.DSACK_W(DSACK_W), .STAT_STAGES(1)) uut (
    .clk(clk), .rst(rst), .need_i(need_i), .done_i(done_i),
    .area_chg_i(area_chg_i), .async_mode_i(async_mode_i),
    .bg_n_i(bg_n_i), .bgack_n_i(bgack_n_i), .as_n_i(as_n_i),
    .dsack_n_i(dsack_n_i), .sterm_n_i(sterm_n_i),
    .br_n_o(br_n_o), .bgack_n_o(bgack_n_o), .own_o(own_o)
  );

  // ---------------- reference cycle model built from the requirements
  // model states: 0 idle, 1 requesting, 2 owning, 3 holding
  int   m_st = 0;
  bit   m_rereq = 0;
  logic m_bg = 1, m_bgack = 1, m_as = 1, m_sterm = 1;
  logic [DSACK_W-1:0] m_dsack = '1;

  function automatic bit bus_ok(input logic bg, input logic bgack, input logic as_l,
                                input logic [DSACK_W-1:0] ds, input logic st,
                                input logic async_m);
    return !bg && bgack && as_l && (&ds) && (st || !async_m);
  endfunction

  function automatic int next_state(input int st, input bit ok, input bit rr);
    case (st)
      0: return need_i ? 1 : 0;
      1: return ok ? 2 : 1;
      2: return (done_i || area_chg_i) ? 3 : 2;
      default: return rr ? 1 : 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_st <= 0; m_rereq <= 0;
      m_bg <= 1; m_bgack <= 1; m_as <= 1; m_sterm <= 1; m_dsack <= '1;
    end else begin
      m_st <= next_state(m_st, bus_ok(m_bg, m_bgack, m_as, m_dsack, m_sterm, async_mode_i), m_rereq);
      if (m_st == 2 && (done_i || area_chg_i)) m_rereq <= area_chg_i;
      else if (m_st == 3) m_rereq <= 0;
      m_bg <= bg_n_i; m_bgack <= bgack_n_i; m_as <= as_n_i;
      m_sterm <= sterm_n_i; m_dsack <= dsack_n_i;
    end
  end

  function automatic string st_tag(input int st);
    case (st)
      0: return "R2";
      1: return "R3";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  // compare every output with the model; called away from the edge
  task automatic chk_model();
    chk(st_tag(m_st), "br_n",    br_n_o,    logic'(m_st != 1));
    chk(st_tag(m_st), "bgack_n", bgack_n_o, logic'(!(m_st == 2 || m_st == 3)));
    chk(st_tag(m_st), "own",     own_o,     logic'(m_st == 2));
    chk("R9", "overlap", logic'(!br_n_o && !bgack_n_o), 1'b0);
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cycles++;
    chk_model();
  endtask

  task automatic bus_quiet();
    bgack_n_i = 1; as_n_i = 1; dsack_n_i = '1; sterm_n_i = 1;
  endtask

  task automatic wait_idle();
    need_i = 0; area_chg_i = 0; done_i = 1;
    for (int i = 0; i < 6; i++) step();
    done_i = 0;
    step();
  endtask

  // watchdog
  always @(posedge clk) begin
    if (!finished && cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int seed;
    int r;
    seed = 32'h5eed_1234;
    r = $urandom(seed);
    #1;
    // R1: values during reset and right after release
    step();
    chk("R1", "br_n in reset", br_n_o, 1'b1);
    chk("R1", "bgack_n in reset", bgack_n_o, 1'b1);
    rst = 0;
    step();
    chk("R1", "own after reset", own_o, 1'b0);
    chk("R1", "bgack_n after reset", bgack_n_o, 1'b1);

    // R2, R3, R5: request, then busy address strobe delays the claim
    need_i = 1; as_n_i = 0;
    step();
    chk("R2", "request low", br_n_o, 1'b0);
    bg_n_i = 0;
    step(); step();
    chk("R3", "no claim while strobe busy", bgack_n_o, 1'b1);
    as_n_i = 1;
    step();               // register picks up the idle strobe
    chk("R3", "one edge of register delay", bgack_n_o, 1'b1);
    step();
    chk("R5", "claim ack", bgack_n_o, 1'b0);
    chk("R5", "claim own", own_o, 1'b1);
    chk("R5", "request withdrawn", br_n_o, 1'b1);

    // R6: grant and bus traffic ignored while owning
    bg_n_i = 1; bgack_n_i = 0; as_n_i = 0; need_i = 0;
    step(); step(); step();
    chk("R6", "still owning", own_o, 1'b1);
    bus_quiet();

    // R7: done gives one holding cycle
    done_i = 1;
    step();
    done_i = 0;
    chk("R7", "hold ack", bgack_n_o, 1'b0);
    chk("R7", "hold own", own_o, 1'b0);
    step();
    chk("R7", "released", bgack_n_o, 1'b1);
    chk("R7", "no re-request", br_n_o, 1'b1);

    // R4: terminate ignored when asynchronous mode is off
    async_mode_i = 0; sterm_n_i = 0; bg_n_i = 0; need_i = 1;
    for (int i = 0; i < 4; i++) step();
    chk("R4", "owns despite terminate, sync mode", own_o, 1'b1);

    // R8: area change with done together, need low: re-request
    need_i = 0; area_chg_i = 1; done_i = 1;
    step();
    area_chg_i = 0; done_i = 0;
    chk("R8", "hold on area change", bgack_n_o, 1'b0);
    step();
    chk("R8", "re-request after hold", br_n_o, 1'b0);

    // R4: terminate blocks when asynchronous mode is on
    async_mode_i = 1;
    for (int i = 0; i < 4; i++) step();
    chk("R4", "blocked by terminate, async mode", bgack_n_o, 1'b1);
    sterm_n_i = 1;
    step(); step();
    chk("R4", "claims once terminate idle", own_o, 1'b1);
    wait_idle();

    // R3: each data-size acknowledge blocks separately
    for (int b = 0; b < DSACK_W; b++) begin
      dsack_n_i = '1; dsack_n_i[b] = 0; need_i = 1;
      for (int i = 0; i < 4; i++) step();
      chk("R3", "blocked by size ack", own_o, 1'b0);
      dsack_n_i = '1;
      step(); step();
      chk("R3", "claims after size ack idle", own_o, 1'b1);
      wait_idle();
    end

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      need_i     = ($urandom % 2) == 0;
      done_i     = ($urandom % 5) == 0;
      area_chg_i = ($urandom % 8) == 0;
      bg_n_i     = ($urandom % 4) == 0;
      bgack_n_i  = ($urandom % 5) != 0;
      as_n_i     = ($urandom % 5) != 0;
      sterm_n_i  = ($urandom % 4) != 0;
      for (int b = 0; b < DSACK_W; b++) dsack_n_i[b] = ($urandom % 6) != 0;
      if ((n % 250) == 0) async_mode_i = ~async_mode_i;
      step();
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule